// File: doc/BRIEF.md
# Error-Free Floating-Point Adder

This block is a pipelined floating-point adder with two results. It returns the rounded sum `x` and a second floating-point value `e`, which is the exact roundoff of that addition. The pair therefore carries `a + b` with no loss of information. Downstream logic can keep `e` and fold it back in later. A compensated accumulator can be built this way on a single adder, without widening the main datapath.

Each operand is unpacked and the two are ordered by magnitude. The smaller significand is aligned against the larger one inside an exact integer window that is wide enough for every bit that alignment shifts out. The window sum is rounded to nearest with ties to even. The discarded part, or its complement when the result rounds up, is normalised into `e`.

When the exponent gap exceeds the window, the smaller operand cannot change the rounded result. In that case the larger operand becomes `x` and the smaller one becomes `e` directly. Subnormal operands count as zero. NaN and infinity only propagate. The field widths are parameters, and the default is IEEE binary64. A fixed number of cycles separates an accepted operand pair from its result, and a new pair may enter on every clock.

Top module: `errfree_adder`

## Requirements
- R1: With the default field layout (bit 63 sign, bits 62:52 biased exponent, bits 51:0 fraction, an exponent of 2047 for Inf/NaN), `out_sum` is the round-to-nearest-even value of `in_a + in_b` for normal operands whose sum lies in the normal range.
- R2: For such operands, `in_a + in_b = out_sum + out_err` holds exactly, and `out_err` is the exact roundoff.
- R3: A sum that lies exactly halfway between two representable values rounds to the one with an even fraction LSB. `out_err` then carries the other half, with a sign opposite to the direction of rounding.
- R4: The magnitude of `out_err` never exceeds half an ulp of `out_sum`.
- R5: An exact addition gives `out_err` = +0 (all bits zero). A complete cancellation also gives `out_sum` = +0.
- R6: When the exponent gap is larger than the alignment window, `out_sum` equals the larger operand and `out_err` equals the smaller operand bit for bit.
- R7: An operand whose biased exponent is 0 is treated as a zero of its sign. The sum of two negative zeros is -0.
- R8: A NaN operand, or the sum of two infinities of opposite sign, gives a NaN `out_sum` and `out_err` = +0. Any other infinite operand gives that infinity and `out_err` = +0.
- R9: A finite sum whose rounded exponent reaches 2047 gives an infinity of the sum's sign and `out_err` = +0.
- R10: `out_valid` rises exactly `LATENCY` cycles (14 by default) after each accepted `in_valid`, one result per input. Results keep input order. `out_valid` is low after reset.
- R11: Neither output is ever subnormal: a result below the normal range is flushed to a zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| in_a | input | 1+EXP_W+MAN_W | First operand |
| in_b | input | 1+EXP_W+MAN_W | Second operand |
| out_valid | output | 1 | Result pair is valid this cycle |
| out_sum | output | 1+EXP_W+MAN_W | Rounded sum |
| out_err | output | 1+EXP_W+MAN_W | Exact roundoff of the sum |

## Verification
Two situations are hard to reach from the ports, and the stimulus aims at both.

The first is a roundoff whose sign flips because the window sum rounded up across a binade. This happens when a subtraction borrows just below a power of two, or when a round-half case lands on an odd fraction. Random operands rarely produce it, so the random generator has modes for it. One mode flips the sign of an operand and perturbs only its low fraction bits, which gives near-total cancellation and borrow chains. Another uses sparse fractions, so that halfway remainders occur often.

The second is the far-operand bypass. A mode draws exponent gaps just past the alignment window, and directed pairs pin down exact ties in both parities.

// File: rtl/fpa_pkg.sv
// Package: shared types for the error-free adder pipeline.
// Assumes nothing beyond IEEE-style sign/exponent/fraction packing.
package fpa_pkg;

    // Result class decided from the operand specials in the first stage.
    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } res_cls_e;

endpackage

// File: rtl/fpa_align.sv
// Stage 1: unpacks both operands and flushes subnormals to zero.
// It classifies the specials, orders the operands by magnitude and
// computes the alignment shift. Assumes the window margin G = MAN_W+3
// fits in EXP_W bits. It registers everything for stage 2.
module fpa_align
    import fpa_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [EXP_W+MAN_W:0]      in_a,
    input  logic [EXP_W+MAN_W:0]      in_b,
    output logic                      v_o,
    output res_cls_e                  cls_o,
    output logic                      csign_o,
    output logic                      far_o,
    output logic                      sub_o,
    output logic                      sbig_o,
    output logic [EXP_W-1:0]          ebig_o,
    output logic [MAN_W:0]            mbig_o,
    output logic [MAN_W:0]            msmall_o,
    output logic [$clog2(MAN_W+4)-1:0] sh_o,
    output logic [EXP_W+MAN_W:0]      xfar_o,
    output logic [EXP_W+MAN_W:0]      efar_o
);
    localparam int G   = MAN_W + 3;
    localparam int SHW = $clog2(MAN_W + 4);
    localparam logic [EXP_W-1:0] EMAX = '1;

    logic sa, sb;
    logic [EXP_W-1:0] ea, eb, eaz, ebz, ebig, esml, diff;
    logic [MAN_W-1:0] fa, fb;
    logic [MAN_W:0]   ma, mb;
    logic za, zb, ia, ib, na, nb, swap, far;
    res_cls_e cls;
    logic csign;

    assign {sa, ea, fa} = in_a;
    assign {sb, eb, fb} = in_b;

    // Operand decode, flush to zero and magnitude ordering.
    always_comb begin
        za   = (ea == '0);
        zb   = (eb == '0);
        ia   = (ea == EMAX) && (fa == '0);
        ib   = (eb == EMAX) && (fb == '0);
        na   = (ea == EMAX) && (fa != '0);
        nb   = (eb == EMAX) && (fb != '0);
        ma   = za ? '0 : {1'b1, fa};
        mb   = zb ? '0 : {1'b1, fb};
        eaz  = za ? '0 : ea;
        ebz  = zb ? '0 : eb;
        swap = {ebz, mb} > {eaz, ma};
        ebig = swap ? ebz : eaz;
        esml = swap ? eaz : ebz;
        diff = ebig - esml;
        far  = diff > EXP_W'(G);
    end

    // Special-result classification ahead of the arithmetic.
    always_comb begin
        cls   = CLS_NUM;
        csign = 1'b0;
        if (na || nb || (ia && ib && (sa != sb))) begin
            cls = CLS_NAN;
        end else if (ia || ib) begin
            cls   = CLS_INF;
            csign = ia ? sa : sb;
        end else if (za && zb) begin
            cls   = CLS_ZERO;
            csign = sa & sb;
        end
    end

    // Pipeline register for stage 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o      <= 1'b0;
            cls_o    <= CLS_NUM;
            csign_o  <= 1'b0;
            far_o    <= 1'b0;
            sub_o    <= 1'b0;
            sbig_o   <= 1'b0;
            ebig_o   <= '0;
            mbig_o   <= '0;
            msmall_o <= '0;
            sh_o     <= '0;
            xfar_o   <= '0;
            efar_o   <= '0;
        end else begin
            v_o      <= in_valid;
            cls_o    <= cls;
            csign_o  <= csign;
            far_o    <= far;
            sub_o    <= sa ^ sb;
            sbig_o   <= swap ? sb : sa;
            ebig_o   <= ebig;
            mbig_o   <= swap ? mb : ma;
            msmall_o <= swap ? ma : mb;
            sh_o     <= far ? '0 : SHW'(G - int'(diff));
            xfar_o   <= swap ? in_b : in_a;
            efar_o   <= swap ? (za ? '0 : in_a) : (zb ? '0 : in_b);
        end
    end
endmodule

// File: rtl/fpa_round.sv
// Stage 2: forms the exact aligned sum in a window of P+G+1 bits and
// rounds it to nearest-even. It extracts the magnitude and sign of the
// roundoff. Assumes the stage 1 ordering (big >= small in magnitude).
module fpa_round #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        v_i,
    input  logic                        sub_i,
    input  logic                        sbig_i,
    input  logic [EXP_W-1:0]            ebig_i,
    input  logic [MAN_W:0]              mbig_i,
    input  logic [MAN_W:0]              msmall_i,
    input  logic [$clog2(MAN_W+4)-1:0]  sh_i,
    output logic                        v_o,
    output logic                        zero_o,
    output logic                        sx_o,
    output logic                        se_o,
    output logic signed [EXP_W+2:0]     ex_o,
    output logic signed [EXP_W+2:0]     ebase_o,
    output logic [MAN_W-1:0]            frac_o,
    output logic [MAN_W+4:0]            emag_o
);
    localparam int P   = MAN_W + 1;
    localparam int G   = MAN_W + 3;
    localparam int SW  = P + G + 1;
    localparam int EMW = G + 2;
    localparam int EXW = EXP_W + 3;

    logic [SW-1:0] opa, opb, s, unit, mask, rem, half;
    logic [P:0]    q, qp;
    logic          up, carry, big_enough;
    logic [MAN_W-1:0] frac;
    logic [EMW-1:0]   emag;
    int lead, r, lsh, exn;

    // Exact aligned sum of the two significands.
    always_comb begin
        opa = SW'(mbig_i) << G;
        opb = SW'(msmall_i) << sh_i;
        s   = sub_i ? (opa - opb) : (opa + opb);
    end

    // Position of the leading one of the window sum.
    always_comb begin
        lead = 0;
        for (int i = 0; i < SW; i++) begin
            if (s[i]) lead = i;
        end
    end

    // Round to nearest-even and derive the roundoff magnitude.
    always_comb begin
        big_enough = (lead >= P - 1);
        r     = big_enough ? (lead - (P - 1)) : 0;
        lsh   = big_enough ? 0 : ((P - 1) - lead);
        unit  = SW'(1) << r;
        mask  = unit - SW'(1);
        rem   = s & mask;
        half  = unit >> 1;
        q     = (P+1)'(s >> r);
        up    = (r > 0) && ((rem > half) || ((rem == half) && q[0]));
        qp    = q + {{P{1'b0}}, up};
        carry = big_enough && qp[P];
        if (big_enough) frac = carry ? '0 : qp[MAN_W-1:0];
        else            frac = MAN_W'(s << lsh);
        emag  = EMW'(up ? (unit - rem) : rem);
        exn   = int'(ebig_i) + lead - (P - 1) - G + (carry ? 1 : 0);
    end

    // Pipeline register for stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o     <= 1'b0;
            zero_o  <= 1'b0;
            sx_o    <= 1'b0;
            se_o    <= 1'b0;
            ex_o    <= '0;
            ebase_o <= '0;
            frac_o  <= '0;
            emag_o  <= '0;
        end else begin
            v_o     <= v_i;
            zero_o  <= (s == '0);
            sx_o    <= sbig_i;
            se_o    <= up ? ~sbig_i : sbig_i;
            ex_o    <= EXW'(exn);
            ebase_o <= EXW'(int'(ebig_i) - MAN_W - G);
            frac_o  <= frac;
            emag_o  <= emag;
        end
    end
endmodule

// File: rtl/fpa_pack.sv
// Stage 3: normalises the roundoff into a floating-point value and packs
// both results. It applies specials, overflow, underflow flush and the
// far-operand bypass. Assumes the stage 1 and stage 2 fields of the same
// pair arrive together.
module fpa_pack
    import fpa_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_i,
    input  res_cls_e                 cls_i,
    input  logic                     csign_i,
    input  logic                     far_i,
    input  logic [EXP_W+MAN_W:0]     xfar_i,
    input  logic [EXP_W+MAN_W:0]     efar_i,
    input  logic                     zero_i,
    input  logic                     sx_i,
    input  logic                     se_i,
    input  logic signed [EXP_W+2:0]  ex_i,
    input  logic signed [EXP_W+2:0]  ebase_i,
    input  logic [MAN_W-1:0]         frac_i,
    input  logic [MAN_W+4:0]         emag_i,
    output logic                     v_o,
    output logic [EXP_W+MAN_W:0]     x_o,
    output logic [EXP_W+MAN_W:0]     e_o
);
    localparam int P    = MAN_W + 1;
    localparam int EMW  = MAN_W + 5;
    localparam int EMAX = (1 << EXP_W) - 1;
    localparam int FW   = 1 + EXP_W + MAN_W;

    logic [P-1:0]  mn;
    logic [FW-1:0] x, e, e_num;
    int le, exe, exx;

    // Leading one of the roundoff magnitude.
    always_comb begin
        le = 0;
        for (int i = 0; i < EMW; i++) begin
            if (emag_i[i]) le = i;
        end
    end

    // Normalised roundoff value.
    always_comb begin
        if (le <= P - 1) mn = P'(emag_i << ((P - 1) - le));
        else             mn = P'(emag_i >> (le - (P - 1)));
        exe = int'(ebase_i) + le;
        if ((emag_i == '0) || (exe <= 0)) e_num = '0;
        else e_num = {se_i, EXP_W'(exe), mn[MAN_W-1:0]};
    end

    // Result selection and packing.
    always_comb begin
        exx = int'(ex_i);
        x   = '0;
        e   = '0;
        unique case (cls_i)
            CLS_NAN:  x = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
            CLS_INF:  x = {csign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            CLS_ZERO: x = {csign_i, {(EXP_W+MAN_W){1'b0}}};
            default: begin
                if (far_i) begin
                    x = xfar_i;
                    e = efar_i;
                end else if (zero_i) begin
                    x = '0;
                end else if (exx >= EMAX) begin
                    x = {sx_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
                end else if (exx <= 0) begin
                    x = {sx_i, {(EXP_W+MAN_W){1'b0}}};
                end else begin
                    x = {sx_i, EXP_W'(exx), frac_i};
                    e = e_num;
                end
            end
        endcase
    end

    // Pipeline register for stage 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            e_o <= '0;
        end else begin
            v_o <= v_i;
            x_o <= x;
            e_o <= e;
        end
    end
endmodule

// File: rtl/fpa_delay.sv
// Pads the three compute stages out to the configured latency with a
// register chain. Assumes DEPTH >= 0. A depth of zero is a plain wire.
module fpa_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] d_o
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign d_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] taps [DEPTH];
            // Shift the payload one position per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= d_i;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end
            assign d_o = taps[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/errfree_adder.sv
// Top: pipelined adder that returns the rounded sum and its exact
// roundoff. Three compute stages are followed by a delay chain up to
// LATENCY. Assumes LATENCY >= 3. Subnormals are flushed and NaN/Inf only
// propagate.
module errfree_adder
    import fpa_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int MAN_W   = 52,
    parameter int LATENCY = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] in_a,
    input  logic [EXP_W+MAN_W:0] in_b,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] out_sum,
    output logic [EXP_W+MAN_W:0] out_err
);
    localparam int FW  = 1 + EXP_W + MAN_W;
    localparam int SHW = $clog2(MAN_W + 4);
    localparam int DLY = (LATENCY > 3) ? (LATENCY - 3) : 0;

    logic v1, csign1, far1, sub1, sbig1;
    res_cls_e cls1, cls2;
    logic csign2, far2;
    logic [EXP_W-1:0] ebig1;
    logic [MAN_W:0]   mbig1, msmall1;
    logic [SHW-1:0]   sh1;
    logic [FW-1:0]    xfar1, efar1, xfar2, efar2;
    logic v2, zero2, sx2, se2;
    logic signed [EXP_W+2:0] ex2, ebase2;
    logic [MAN_W-1:0] frac2;
    logic [MAN_W+4:0] emag2;
    logic v3;
    logic [FW-1:0] x3, e3;

    fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .v_o(v1), .cls_o(cls1), .csign_o(csign1), .far_o(far1), .sub_o(sub1),
        .sbig_o(sbig1), .ebig_o(ebig1), .mbig_o(mbig1), .msmall_o(msmall1),
        .sh_o(sh1), .xfar_o(xfar1), .efar_o(efar1)
    );

    fpa_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .clk(clk), .rst_n(rst_n), .v_i(v1), .sub_i(sub1), .sbig_i(sbig1),
        .ebig_i(ebig1), .mbig_i(mbig1), .msmall_i(msmall1), .sh_i(sh1),
        .v_o(v2), .zero_o(zero2), .sx_o(sx2), .se_o(se2), .ex_o(ex2),
        .ebase_o(ebase2), .frac_o(frac2), .emag_o(emag2)
    );

    // Carry the stage 1 side fields alongside stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls2   <= CLS_NUM;
            csign2 <= 1'b0;
            far2   <= 1'b0;
            xfar2  <= '0;
            efar2  <= '0;
        end else begin
            cls2   <= cls1;
            csign2 <= csign1;
            far2   <= far1;
            xfar2  <= xfar1;
            efar2  <= efar1;
        end
    end

    fpa_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .v_i(v2), .cls_i(cls2), .csign_i(csign2),
        .far_i(far2), .xfar_i(xfar2), .efar_i(efar2), .zero_i(zero2),
        .sx_i(sx2), .se_i(se2), .ex_i(ex2), .ebase_i(ebase2), .frac_i(frac2),
        .emag_i(emag2), .v_o(v3), .x_o(x3), .e_o(e3)
    );

    fpa_delay #(.WIDTH(2*FW+1), .DEPTH(DLY)) u_delay (
        .clk(clk), .rst_n(rst_n),
        .d_i({v3, x3, e3}),
        .d_o({out_valid, out_sum, out_err})
    );
endmodule

// File: rtl/errfree_adder_chk.sv
// Checker bound to errfree_adder. It tracks input validity against output
// timing and checks the structural properties of every result pair.
module errfree_adder_chk #(
    parameter int EXP_W   = 11,
    parameter int MAN_W   = 52,
    parameter int LATENCY = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [EXP_W+MAN_W:0] in_a,
    input logic [EXP_W+MAN_W:0] in_b,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] out_sum,
    input logic [EXP_W+MAN_W:0] out_err
);
    localparam int EMAX = (1 << EXP_W) - 1;

    logic [LATENCY-1:0] vtrack;
    logic [EXP_W-1:0] ex, ee;
    logic [MAN_W-1:0] fx, fe;
    logic unused_ok;

    assign ex = out_sum[EXP_W+MAN_W-1:MAN_W];
    assign fx = out_sum[MAN_W-1:0];
    assign ee = out_err[EXP_W+MAN_W-1:MAN_W];
    assign fe = out_err[MAN_W-1:0];
    assign unused_ok = ^{in_a, in_b};

    // Independent record of when inputs were accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) vtrack <= '0;
        else        vtrack <= {vtrack[LATENCY-2:0], in_valid};
    end

    a_r10_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vtrack[LATENCY-1]);

    a_r8_special_zero_err: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(ex) == EMAX)) |-> (out_err == '0));

    a_r5_zero_sum_zero_err: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_sum[EXP_W+MAN_W-1:0] == '0)) |-> (out_err == '0));

    a_r4_err_half_ulp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (ex != '0) && (int'(ex) != EMAX) && (out_err != '0)) |->
        ((int'(ee) < int'(ex) - MAN_W - 1) ||
         ((int'(ee) == int'(ex) - MAN_W - 1) && (fe == '0))));

    a_r11_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((ex != '0) || (fx == '0)) && ((ee != '0) || (fe == '0))));
endmodule

bind errfree_adder errfree_adder_chk #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .LATENCY(LATENCY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum), .out_err(out_err)
);

// File: tb/errfree_adder_test.sv
// Bench: directed corners plus seeded random pairs. Expected sums come
// from real addition and expected roundoffs from the two-sum identity.
module errfree_adder_test;
    localparam int EXP_W = 11;
    localparam int MAN_W = 52;
    localparam int LATENCY = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [63:0] in_a = '0, in_b = '0;
    logic out_valid;
    logic [63:0] out_sum, out_err;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [63:0] qa[$], qb[$];
    int qc[$];
    string qt[$];

    always #10 clk = ~clk;

    errfree_adder #(.EXP_W(EXP_W), .MAN_W(MAN_W), .LATENCY(LATENCY)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_sum(out_sum), .out_err(out_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] ftz(logic [63:0] v);
        return (v[62:52] == 11'd0) ? {v[63], 63'd0} : v;
    endfunction

    function automatic bit is_nan(logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
    endfunction

    // Reference: real sum and the two-sum roundoff, zeros canonical +0.
    task automatic ref_add(input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] x, output logic [63:0] e);
        real ra, rb, s, bb, er;
        ra = $bitstoreal(ftz(a));
        rb = $bitstoreal(ftz(b));
        s  = ra + rb;
        x  = $realtobits(s);
        if (x[62:52] == 11'h7FF) e = '0;
        else begin
            bb = s - ra;
            er = (ra - (s - bb)) + (rb - bb);
            e  = $realtobits(er);
            if (e[62:0] == 63'd0) e = '0;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    // Compare one result pair against the reference.
    task automatic check_out();
        logic [63:0] a, b, xr, er;
        int c;
        string tag;
        if (qa.size() == 0) begin
            chk(1'b0, "R10 output without input", {63'd0, out_valid}, 64'd0);
            return;
        end
        a = qa.pop_front(); b = qb.pop_front(); c = qc.pop_front(); tag = qt.pop_front();
        ref_add(a, b, xr, er);
        chk((cyc - c) == LATENCY, "R10 latency", 64'(cyc - c), 64'(LATENCY));
        if (is_nan(xr)) begin
            chk(is_nan(out_sum) && (out_err == '0), {tag, " R8 nan"}, out_sum, xr);
        end else begin
            chk(out_sum == xr, {tag, " R1 sum"}, out_sum, xr);
            chk(out_err == er, {tag, " R2 err"}, out_err, er);
            if ((out_sum[62:52] != 11'd0) && (out_sum[62:52] != 11'h7FF) && (out_err != '0))
                chk(int'(out_err[62:52]) <= int'(out_sum[62:52]) - MAN_W - 1,
                    {tag, " R4 bound"}, out_err, out_sum);
            chk((out_sum[62:52] != 11'd0) || (out_sum[51:0] == 52'd0),
                {tag, " R11 no subnormal"}, out_sum, 64'd0);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) check_out();
    end

    task automatic send(input logic [63:0] a, input logic [63:0] b, input string tag);
        in_valid = 1'b1; in_a = a; in_b = b;
        qa.push_back(a); qb.push_back(b); qc.push_back(cyc); qt.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [51:0] r52();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[51:0];
    endfunction

    function automatic int clampe(int e);
        if (e < 1) return 1;
        if (e > 2046) return 2046;
        return e;
    endfunction

    task automatic send_random();
        bit sa, sb;
        int ea, eb, mode;
        logic [51:0] fa, fb;
        sa = 1'($urandom()); sb = 1'($urandom());
        ea = 400 + int'($urandom() % 1200);
        fa = r52(); fb = r52();
        mode = int'($urandom() % 6);
        case (mode)
            0: eb = ea + int'($urandom() % 121) - 60;
            1: begin sb = ~sa; eb = ea - int'($urandom() % 2); fb = fa ^ (r52() >> ($urandom() % 52)); end
            2: eb = ea - 56 - int'($urandom() % 150);
            3: begin sb = ~sa; eb = ea; fb = fa; end
            4: begin fa = {r52() & 52'hF000000000000}; fb = 52'($urandom() % 16) << ($urandom() % 48);
                     eb = ea - int'($urandom() % 60); end
            default: eb = ea + int'($urandom() % 401) - 200;
        endcase
        send({sa, 11'(ea), fa}, {sb, 11'(clampe(eb)), fb}, "R1R2 random");
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 reset out_valid low", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 ties in both parities
        send(64'h3FF0000000000000, 64'h3CA0000000000000, "R3 tie even");
        send(64'h3FF0000000000001, 64'h3CA0000000000000, "R3 tie odd");
        send(64'hBFF0000000000001, 64'hBCA0000000000000, "R3 tie odd neg");
        // R5 exact and cancelling sums
        send(64'h4008000000000000, 64'hBFF0000000000000, "R5 exact");
        send(64'h4123456789ABCDEF, 64'hC123456789ABCDEF, "R5 cancel");
        // R6 far operands
        send(64'h3FF0000000000000, 64'h3C30000000000000, "R6 far");
        send(64'hBC30000000000000, 64'h3FF0000000000000, "R6 far swapped");
        // R7 zeros and subnormals
        send(64'h8000000000000000, 64'h8000000000000000, "R7 neg zeros");
        send(64'h0000000000000001, 64'h3FF0000000000000, "R7 subnormal");
        send(64'h800FFFFFFFFFFFFF, 64'h0000000000000000, "R7 subnormal zero");
        // R8 specials
        send(64'h7FF8000000000000, 64'h3FF0000000000000, "R8 nan in");
        send(64'h7FF0000000000000, 64'hFFF0000000000000, "R8 inf minus inf");
        send(64'hFFF0000000000000, 64'h3FF0000000000000, "R8 inf");
        // R9 overflow
        send(64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, "R9 overflow");
        send(64'h7FEFFFFFFFFFFFFF, 64'h7C9FFFFFFFFFFFFF, "R9 round to inf");
        repeat (LATENCY + 2) @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            send_random();
            if (($urandom() % 16) == 0) @(negedge clk);
        end
        repeat (LATENCY + 4) @(negedge clk);
        chk(qa.size() == 0, "R10 every input produced a result", 64'(qa.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule